// File: doc/BRIEF.md
# Ratiometric Count Calibration Unit

This block turns the three time counts gathered during one measurement cycle of a ramp-type converter into a calibrated reading. The three counts are the zero input, the full-scale reference input and the unknown input. The block takes the zero count off both the unknown and the reference count. It multiplies the corrected unknown by a fixed scale constant and divides the product by the corrected reference. The default scale constant is ten million, so the quotient resolves one part in 10^7 of full scale.

Each result is normalized against zero and reference readings taken in the same cycle. Any offset cancels, including a constant error left in the integrator. Any gain drift in the analog chain also cancels, so no calibration constants are stored. A caller applies a one-cycle start strobe together with the three counts. The caller then waits for the done strobe, which carries the quotient and two status flags. After done the unit accepts the next start.

Top module: `ratio_cal_unit`

## Requirements
- R1: When reference > zero and unknown ≥ zero, the result is floor((unknown − zero) × SCALE / (reference − zero)), with no saturation. For example, unknown = zero gives 0 and unknown = reference gives exactly SCALE.
- R2: When reference > zero and unknown < zero, the result is 0, `underrange` is 1 and `err_ref` is 0.
- R3: When reference ≤ zero, the result is 0, `err_ref` is 1 and `underrange` is 0, whatever the unknown count is.
- R4: `done` is high for exactly one cycle per accepted start. `busy` is already low in that cycle. `result`, `err_ref` and `underrange` hold their values until the next `done`.
- R5: A `start` applied while `busy` is high is ignored. It produces no extra `done`, and its counts do not alter the pending result.
- R6: A `start` sampled with `busy` low is accepted. `busy` is high from the next cycle until `done`.
- R7: Counting from the clock edge that accepts `start`, `done` goes high after 2×CNT_W+3 edges for a division and after 2 edges when `err_ref` is set.
- R8: After synchronous reset, `busy`, `done`, `err_ref` and `underrange` are 0 and `result` is 0.

Ports are listed below in the order of the port list.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle request; the three counts are sampled with it |
| cnt_zero | input | CNT_W | Count taken with the zero input selected |
| cnt_ref | input | CNT_W | Count taken with the full-scale reference selected |
| cnt_unk | input | CNT_W | Count taken with the unknown input selected |
| busy | output | 1 | High while a calibration is in progress |
| done | output | 1 | One-cycle strobe; result and flags are valid |
| result | output | 2×CNT_W | Calibrated quotient |
| err_ref | output | 1 | Reference count not above zero count |
| underrange | output | 1 | Unknown count below zero count |

## Verification
The bench builds the block with the default values CNT_W = 24 and SCALE = 10,000,000. With these values the divider runs for its full 48 steps and the product reaches its full 48-bit width. A one-count reference with an unknown at the top of the count range gives a quotient near 2^47, which exercises the upper quotient bits. The same settings cover a small reference that forces truncation, unknown equal to reference, and both error orderings. They also cover a start applied during a running division.

// File: rtl/rcal_pkg.sv
package rcal_pkg;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_MULT = 3'd1,
    ST_LOAD = 3'd2,
    ST_DIV  = 3'd3,
    ST_FIN  = 3'd4
  } rcal_state_t;

endpackage

// File: rtl/rcal_front.sv
module rcal_front #(
  parameter int unsigned CNT_W = 24,
  parameter int unsigned SCALE = 10_000_000,
  parameter int unsigned PROD_W = 2 * CNT_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic              mul_en,
  input  logic [CNT_W-1:0]  zero_in,
  input  logic [CNT_W-1:0]  ref_in,
  input  logic [CNT_W-1:0]  unk_in,
  output logic [CNT_W-1:0]  den_out,
  output logic [PROD_W-1:0] prod_out,
  output logic              bad_ref,
  output logic              below_zero
);

  logic [CNT_W-1:0]  num_q;
  logic [CNT_W-1:0]  den_q;
  logic [PROD_W-1:0] prod_q;
  logic              bad_q;
  logic              low_q;
  logic              ref_ok;
  logic              unk_ok;

  always_comb begin
    ref_ok = ref_in > zero_in;
    unk_ok = unk_in >= zero_in;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      num_q  <= '0;
      den_q  <= '0;
      bad_q  <= 1'b0;
      low_q  <= 1'b0;
      prod_q <= '0;
    end else begin
      if (load) begin
        den_q <= ref_ok ? (ref_in - zero_in) : '0;
        num_q <= (ref_ok && unk_ok) ? (unk_in - zero_in) : '0;
        bad_q <= !ref_ok;
        low_q <= ref_ok && !unk_ok;
      end
      if (mul_en) begin
        prod_q <= PROD_W'(num_q) * PROD_W'(SCALE);
      end
    end
  end

  assign den_out    = den_q;
  assign prod_out   = prod_q;
  assign bad_ref    = bad_q;
  assign below_zero = low_q;

endmodule

// File: rtl/rcal_divider.sv
module rcal_divider #(
  parameter int unsigned NUM_W = 48,
  parameter int unsigned DEN_W = 24
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [NUM_W-1:0] dividend,
  input  logic [DEN_W-1:0] divisor,
  output logic [NUM_W-1:0] quotient,
  output logic             q_valid,
  output logic             active
);

  localparam int unsigned CW = $clog2(NUM_W + 1);

  logic [DEN_W-1:0] rem_q;
  logic [DEN_W-1:0] den_q;
  logic [NUM_W-1:0] quot_q;
  logic [CW-1:0]    cnt_q;
  logic             act_q;
  logic             vld_q;
  logic [DEN_W:0]   shifted;
  logic [DEN_W:0]   trial;
  logic             fits;

  always_comb begin
    shifted = {rem_q, quot_q[NUM_W-1]};
    trial   = shifted - {1'b0, den_q};
    fits    = shifted >= {1'b0, den_q};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rem_q  <= '0;
      den_q  <= '0;
      quot_q <= '0;
      cnt_q  <= '0;
      act_q  <= 1'b0;
      vld_q  <= 1'b0;
    end else begin
      vld_q <= 1'b0;
      if (load) begin
        rem_q  <= '0;
        den_q  <= divisor;
        quot_q <= dividend;
        cnt_q  <= CW'(NUM_W);
        act_q  <= 1'b1;
      end else if (act_q) begin
        if (fits) begin
          rem_q  <= trial[DEN_W-1:0];
          quot_q <= {quot_q[NUM_W-2:0], 1'b1};
        end else begin
          rem_q  <= shifted[DEN_W-1:0];
          quot_q <= {quot_q[NUM_W-2:0], 1'b0};
        end
        cnt_q <= cnt_q - CW'(1);
        if (cnt_q == CW'(1)) begin
          act_q <= 1'b0;
          vld_q <= 1'b1;
        end
      end
    end
  end

  assign quotient = quot_q;
  assign q_valid  = vld_q;
  assign active   = act_q;

  // R1
  rem_below_div_chk: assert property (@(posedge clk) disable iff (rst)
    act_q |-> (rem_q < den_q));

  // R7
  valid_single_chk: assert property (@(posedge clk) disable iff (rst)
    vld_q |=> !vld_q);

endmodule

// File: rtl/ratio_cal_unit.sv
module ratio_cal_unit #(
  parameter int unsigned CNT_W = 24,
  parameter int unsigned SCALE = 10_000_000
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 start,
  input  logic [CNT_W-1:0]     cnt_zero,
  input  logic [CNT_W-1:0]     cnt_ref,
  input  logic [CNT_W-1:0]     cnt_unk,
  output logic                 busy,
  output logic                 done,
  output logic [2*CNT_W-1:0]   result,
  output logic                 err_ref,
  output logic                 underrange
);
  import rcal_pkg::*;

  localparam int unsigned PROD_W = 2 * CNT_W;

  rcal_state_t       state_q;
  logic [CNT_W-1:0]  den;
  logic [PROD_W-1:0] prod;
  logic              bad_ref;
  logic              below_zero;
  logic [PROD_W-1:0] quot;
  logic              q_valid;
  logic              dv_active;
  logic              accept;
  logic [PROD_W-1:0] res_q;
  logic              busy_q;
  logic              done_q;
  logic              err_q;
  logic              und_q;

  assign accept = start && (state_q == ST_IDLE);

  rcal_front #(
    .CNT_W (CNT_W),
    .SCALE (SCALE),
    .PROD_W(PROD_W)
  ) u_front (
    .clk       (clk),
    .rst       (rst),
    .load      (accept),
    .mul_en    (state_q == ST_MULT),
    .zero_in   (cnt_zero),
    .ref_in    (cnt_ref),
    .unk_in    (cnt_unk),
    .den_out   (den),
    .prod_out  (prod),
    .bad_ref   (bad_ref),
    .below_zero(below_zero)
  );

  rcal_divider #(
    .NUM_W(PROD_W),
    .DEN_W(CNT_W)
  ) u_div (
    .clk     (clk),
    .rst     (rst),
    .load    (state_q == ST_LOAD),
    .dividend(prod),
    .divisor (den),
    .quotient(quot),
    .q_valid (q_valid),
    .active  (dv_active)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      res_q   <= '0;
      busy_q  <= 1'b0;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
      und_q   <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (accept) begin
            busy_q  <= 1'b1;
            state_q <= ST_MULT;
          end
        end
        ST_MULT: state_q <= bad_ref ? ST_FIN : ST_LOAD;
        ST_LOAD: state_q <= ST_DIV;
        ST_DIV: begin
          if (q_valid) begin
            res_q   <= quot;
            err_q   <= 1'b0;
            und_q   <= below_zero;
            done_q  <= 1'b1;
            busy_q  <= 1'b0;
            state_q <= ST_IDLE;
          end
        end
        ST_FIN: begin
          res_q   <= '0;
          err_q   <= 1'b1;
          und_q   <= 1'b0;
          done_q  <= 1'b1;
          busy_q  <= 1'b0;
          state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign busy       = busy_q;
  assign done       = done_q;
  assign result     = res_q;
  assign err_ref    = err_q;
  assign underrange = und_q;

  // R4
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done_q |=> !done_q);

  // R4
  done_idle_chk: assert property (@(posedge clk) disable iff (rst)
    done_q |-> !busy_q);

  // R6
  busy_rise_chk: assert property (@(posedge clk) disable iff (rst)
    (start && !busy_q) |=> busy_q);

  // R3
  err_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (done_q && err_q) |-> (res_q == '0 && !und_q));

  // R2
  under_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (done_q && und_q) |-> (res_q == '0 && !err_q));

  // R7
  div_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !busy_q |-> !dv_active);

endmodule

// File: tb/sim_ratio_cal_unit.sv
module sim_ratio_cal_unit;

  localparam int unsigned CNT_W = 24;
  localparam int unsigned SCALE = 10_000_000;
  localparam int unsigned PROD_W = 2 * CNT_W;
  localparam longint unsigned CMAX = (64'd1 << CNT_W) - 1;

  typedef struct {
    longint unsigned res;
    bit              err;
    bit              und;
    int              lat;
    int              stamp;
    string           tag;
  } exp_t;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              start = 1'b0;
  logic [CNT_W-1:0]  cnt_zero = '0;
  logic [CNT_W-1:0]  cnt_ref = '0;
  logic [CNT_W-1:0]  cnt_unk = '0;
  logic              busy;
  logic              done;
  logic [PROD_W-1:0] result;
  logic              err_ref;
  logic              underrange;

  int   cyc = 0;
  int   vectors = 0;
  int   miscompares = 0;
  int   issued = 0;
  int   seen = 0;
  exp_t sb[$];

  ratio_cal_unit #(.CNT_W(CNT_W), .SCALE(SCALE)) u0 (
    .clk(clk), .rst(rst), .start(start),
    .cnt_zero(cnt_zero), .cnt_ref(cnt_ref), .cnt_unk(cnt_unk),
    .busy(busy), .done(done), .result(result),
    .err_ref(err_ref), .underrange(underrange)
  );

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string tag, input longint unsigned act,
                       input longint unsigned expv);
    vectors++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
    end
  endtask

  task automatic drive(input longint unsigned z, input longint unsigned f,
                       input longint unsigned u);
    exp_t e;
    while (busy !== 1'b0) @(negedge clk);
    if (f <= z) begin
      e.res = 0; e.err = 1; e.und = 0; e.lat = 2; e.tag = "R3";
    end else if (u < z) begin
      e.res = 0; e.err = 0; e.und = 1; e.lat = PROD_W + 3; e.tag = "R2";
    end else begin
      e.res = ((u - z) * SCALE) / (f - z);
      e.err = 0; e.und = 0; e.lat = PROD_W + 3; e.tag = "R1";
    end
    e.stamp = cyc + 1;
    sb.push_back(e);
    issued++;
    cnt_zero = CNT_W'(z); cnt_ref = CNT_W'(f); cnt_unk = CNT_W'(u);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check(busy === 1'b1, "R6 busy after start", longint'(busy), 1);
  endtask

  // monitor: pops the scoreboard on each done strobe
  always @(negedge clk) begin
    if (!rst && done === 1'b1) begin
      seen++;
      if (sb.size() == 0) begin
        check(1'b0, "R5 unexpected done", 1, 0);
      end else begin
        exp_t e;
        e = sb.pop_front();
        check(result == PROD_W'(e.res), {e.tag, " result"}, result, e.res);
        check(err_ref === e.err && underrange === e.und, {e.tag, " flags err/und"},
              {err_ref, underrange}, {e.err, e.und});
        check((cyc - e.stamp) == e.lat, "R7 latency", cyc - e.stamp, e.lat);
        check(busy === 1'b0, "R4 busy low with done", busy, 0);
      end
    end
  end

  // R4: done lasts one cycle; outputs hold afterwards
  always @(negedge clk) begin
    if (!rst && $past(done) === 1'b1) begin
      check(done === 1'b0, "R4 done width", done, 0);
    end
  end

  initial begin
    repeat (200_000) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    logic [PROD_W-1:0] held;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(busy === 1'b0 && done === 1'b0 && err_ref === 1'b0 && underrange === 1'b0,
          "R8 reset flags", {busy, done, err_ref, underrange}, 0);
    check(result == '0, "R8 reset result", result, 0);

    drive(1000, 2000, 1500);              // R1 midpoint -> SCALE/2
    drive(500, 9000, 500);                // R1 unknown at zero -> 0
    drive(777, 123456, 123456);           // R1 unknown at reference -> SCALE
    drive(0, 3, 1);                       // R1 truncation -> 3333333
    drive(0, 1, CMAX);                    // R1 largest quotient
    drive(0, CMAX, CMAX - 1);             // R1 full-width reference
    drive(5000, 6000, 4999);              // R2 just below zero
    drive(5000, 5000, 9000);              // R3 reference equals zero
    drive(8000, 100, 50);                 // R3 precedes underrange

    // R5: a second start during a running division is ignored
    drive(100, 1100, 600);
    repeat (5) @(negedge clk);
    cnt_zero = 0; cnt_ref = 10; cnt_unk = 10;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    while (busy === 1'b1) @(negedge clk);
    repeat (3) @(negedge clk);
    check(seen == issued, "R5 done count", seen, issued);

    // R4: result holds after done until the next one
    held = result;
    repeat (10) @(negedge clk);
    check(result == held, "R4 result held", result, held);

    for (int i = 0; i < 24; i++) begin
      longint unsigned z, f, u;
      z = longint'($urandom_range(0, 1_000_000));
      f = z + longint'($urandom_range(1, 8_000_000));
      u = longint'($urandom_range(0, 16_000_000));
      drive(z, f, u);
    end

    while (sb.size() != 0) @(negedge clk);
    repeat (5) @(negedge clk);
    check(seen == issued, "R4 one done per start", seen, issued);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

endmodule